// File: doc/BRIEF.md
# Marker-Table Byte Equality Sequencer

This block tells whether two bytes are equal without any bitwise comparison. It owns one reserved 256-byte page of RAM, the marker table, at 0x0200 to 0x02FF. After a start pulse it makes three memory accesses. It writes a "different" marker into the table slot selected by the first byte. It writes a "same" marker into the slot selected by the second byte. It then reads back the slot of the first byte.

If the two bytes match, the second write lands on the first slot and overwrites the marker. The byte read back is therefore 0x00 for a match and 0x80 for a mismatch. Only bit 7 is set in the mismatch case, so a later branch can test the sign of the result.

The sequencer drives a simple single-port memory interface. The read data must be valid in the same cycle as the read strobe. The result byte is held until the next comparison finishes. A one-cycle done pulse marks when it is fresh.

Top module: `marker_eq_engine`

## Requirements
- R1: After reset, both memory strobes and done are low, and the result byte is 0x00.
- R2: In the first cycle after an accepted start, the write strobe is high, the address is 0x02 followed by the latched first byte, and the write data is 0x80.
- R3: In the second cycle, the write strobe is high, the address is 0x02 followed by the latched second byte, and the write data is 0x00.
- R4: In the third cycle, the read strobe is high, the write strobe is low, and the address is again 0x02 followed by the latched first byte.
- R5: Done is high for exactly one cycle, which is the cycle right after the read cycle. The result output equals the byte that was on the read data input during the read cycle.
- R6: With a RAM behind the interface, the result is 0x00 when the two bytes are equal and 0x80 otherwise, whatever the table held before.
- R7: A start seen while a comparison is in progress, including the done cycle, is ignored. No extra memory access follows it.
- R8: Both bytes are captured in the cycle the start is accepted. Later changes on the operand inputs do not alter the addresses used or the result.
- R9: Write and read strobes are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a comparison (taken only when idle) |
| op_a | input | 8 | First byte; selects the slot written with 0x80 and read back |
| op_b | input | 8 | Second byte; selects the slot written with 0x00 |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe, the write takes effect at the clock edge ending the cycle |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle mem_re is high |
| done | output | 1 | One-cycle pulse when the result is updated |
| result | output | 8 | Byte read back from the table: 0x00 for equal, 0x80 for different |

## Verification
The assertions assume two things about the environment. First, start is a clean synchronous level. Second, reset is released only between comparisons. They do not assume anything about the read data, so marker values in the table matter only to the result checks. The stimulus drives every input half a cycle away from the active edge. It pre-fills the modelled page with random bytes. It deliberately pulses start and changes the operand inputs during a running comparison, so the ignore and capture behaviour are exercised without ever violating those timing assumptions.

// File: rtl/marker_eq_pkg.sv
package marker_eq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MARK  = 3'd1,
    ST_CLEAR = 3'd2,
    ST_PROBE = 3'd3,
    ST_DONE  = 3'd4
  } step_t;

endpackage

// File: rtl/meq_operand_hold.sv
module meq_operand_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

endmodule

// File: rtl/meq_step_fsm.sv
module meq_step_fsm
  import marker_eq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output step_t step,
  output logic  accept,
  output logic  busy,
  output logic  capture,
  output logic  finish
);

  step_t step_q;

  function automatic step_t next_step(input step_t cur, input logic go);
    case (cur)
      ST_IDLE:  return go ? ST_MARK : ST_IDLE;
      ST_MARK:  return ST_CLEAR;
      ST_CLEAR: return ST_PROBE;
      ST_PROBE: return ST_DONE;
      default:  return ST_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= next_step(step_q, start);
  end

  assign step    = step_q;
  assign busy    = (step_q != ST_IDLE);
  assign accept  = (step_q == ST_IDLE) && start;
  assign capture = (step_q == ST_PROBE);
  assign finish  = (step_q == ST_DONE);

endmodule

// File: rtl/meq_mem_drive.sv
module meq_mem_drive
  import marker_eq_pkg::*;
#(
  parameter int                     DATA_W   = 8,
  parameter int                     ADDR_W   = 16,
  parameter logic [ADDR_W-DATA_W-1:0] PAGE_SEL = 'h02,
  parameter logic [DATA_W-1:0]      MARK_SET = 8'h80,
  parameter logic [DATA_W-1:0]      MARK_CLR = 8'h00
) (
  input  step_t             step,
  input  logic [DATA_W-1:0] a_q,
  input  logic [DATA_W-1:0] b_q,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              we,
  output logic              re
);

  localparam int PAGE_W = ADDR_W - DATA_W;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [DATA_W-1:0] idx);
    return {PAGE_SEL, idx};
  endfunction

  logic [DATA_W-1:0] idx_sel;

  always_comb begin
    idx_sel = a_q;
    wdata   = MARK_CLR;
    we      = 1'b0;
    re      = 1'b0;
    case (step)
      ST_MARK: begin
        we    = 1'b1;
        wdata = MARK_SET;
      end
      ST_CLEAR: begin
        we      = 1'b1;
        idx_sel = b_q;
      end
      ST_PROBE: re = 1'b1;
      default: ;
    endcase
  end

  generate
    if (PAGE_W > 0) begin : g_paged
      assign addr = slot_addr(idx_sel);
    end else begin : g_flat
      assign addr = idx_sel;
    end
  endgenerate

endmodule

// File: rtl/marker_eq_engine.sv
module marker_eq_engine
  import marker_eq_pkg::*;
#(
  parameter int                       DATA_W   = 8,
  parameter int                       ADDR_W   = 16,
  parameter logic [ADDR_W-DATA_W-1:0] PAGE_SEL = 'h02,
  parameter logic [DATA_W-1:0]        MARK_SET = 8'h80,
  parameter logic [DATA_W-1:0]        MARK_CLR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  step_t             step_w;
  logic              accept_w;
  logic              busy_w;
  logic              capture_w;
  logic              finish_w;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [DATA_W-1:0] result_q;

  meq_step_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (step_w),
    .accept  (accept_w),
    .busy    (busy_w),
    .capture (capture_w),
    .finish  (finish_w)
  );

  meq_operand_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_w),
    .a_in  (op_a),
    .b_in  (op_b),
    .a_q   (a_q),
    .b_q   (b_q)
  );

  meq_mem_drive #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PAGE_SEL (PAGE_SEL),
    .MARK_SET (MARK_SET),
    .MARK_CLR (MARK_CLR)
  ) u_drive (
    .step  (step_w),
    .a_q   (a_q),
    .b_q   (b_q),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .we    (mem_we),
    .re    (mem_re)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (capture_w) result_q <= mem_rdata;
  end

  assign result = result_q;
  assign done   = finish_w;

endmodule

// File: rtl/marker_eq_chk.sv
module marker_eq_chk #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 16,
  parameter logic [DATA_W-1:0] MARK_SET = 8'h80,
  parameter logic [DATA_W-1:0] MARK_CLR = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              busy_w,
  input logic              accept_w
);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !(mem_we || mem_re));

  // R2
  first_write_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> mem_wdata == MARK_SET);

  // R3
  second_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_wdata == MARK_CLR);

  // R4
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> $past(mem_we));

  // R4
  read_same_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr == $past(mem_addr, 2));

  // R5
  done_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_re));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !busy_w && start);

endmodule

bind marker_eq_engine marker_eq_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .MARK_SET (MARK_SET),
  .MARK_CLR (MARK_CLR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .busy_w    (busy_w),
  .accept_w  (accept_w)
);

// File: tb/test_marker_eq_engine.sv
module test_marker_eq_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [7:0]  result;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] page_ram [256];

  always #10 clk = ~clk;

  marker_eq_engine i_marker_eq_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_a      (op_a),
    .op_b      (op_b),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .done      (done),
    .result    (result)
  );

  always_ff @(posedge clk) begin
    if (mem_we) page_ram[mem_addr[7:0]] <= mem_wdata;
  end
  assign mem_rdata = page_ram[mem_addr[7:0]];

  function automatic logic [15:0] exp_slot(input logic [7:0] v);
    return 16'h0200 | {8'h00, v};
  endfunction

  function automatic logic [7:0] exp_result(input logic [7:0] x, input logic [7:0] y);
    return (x == y) ? 8'h00 : 8'h80;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One comparison, with the outputs checked in every cycle.
  // With noisy set, start stays high and the operands change while busy.
  task automatic run_cmp(input logic [7:0] a, input logic [7:0] b, input bit noisy);
    logic [7:0] want;
    logic [7:0] rd_seen;
    want = exp_result(a, b);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = noisy; // R7: start held while busy must be ignored
    if (noisy) begin op_a = ~a; op_b = a ^ 8'h5A; end // R8
    check(mem_we && !mem_re && mem_addr == exp_slot(a) && mem_wdata == 8'h80,
          "R2 mark write", {mem_we, mem_re, mem_addr, mem_wdata}, {2'b10, exp_slot(a), 8'h80});
    @(negedge clk);
    if (noisy) begin op_a = $urandom; op_b = $urandom; end
    check(mem_we && !mem_re && mem_addr == exp_slot(b) && mem_wdata == 8'h00,
          "R3 clear write", {mem_we, mem_re, mem_addr, mem_wdata}, {2'b10, exp_slot(b), 8'h00});
    @(negedge clk);
    check(mem_re && !mem_we && mem_addr == exp_slot(a) && !done,
          "R4 probe read", {done, mem_we, mem_re, mem_addr}, {3'b001, exp_slot(a)});
    rd_seen = mem_rdata;
    @(negedge clk);
    check(done && !mem_we && !mem_re, "R5 done cycle", {done, mem_we, mem_re}, 3'b100);
    check(result == rd_seen, "R5 result is read data", result, rd_seen);
    check(result == want, "R6 equality result", result, want);
    @(negedge clk);
    start = 1'b0;
    check(!done && !mem_we && !mem_re, "R5 R7 R9 back to idle", {done, mem_we, mem_re}, 3'b000);
    check(result == want, "R5 result held", result, want);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd20240517);
    for (int i = 0; i < 256; i++) page_ram[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_we && !mem_re && !done && result == 8'h00, "R1 reset",
          {mem_we, mem_re, done, result}, 11'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_we && !mem_re && !done && result == 8'h00, "R1 after release",
          {mem_we, mem_re, done, result}, 11'h000);

    run_cmp(8'h00, 8'h00, 1'b0);
    run_cmp(8'hFF, 8'hFF, 1'b0);
    run_cmp(8'h00, 8'hFF, 1'b0);
    run_cmp(8'h80, 8'h00, 1'b0);
    run_cmp(8'h7F, 8'h80, 1'b0);
    run_cmp(8'h55, 8'hAA, 1'b0);
    run_cmp(8'h12, 8'h12, 1'b1);
    run_cmp(8'h12, 8'h34, 1'b1);
    run_cmp(8'h34, 8'h12, 1'b1);

    for (int k = 0; k < 200; k++) begin
      logic [7:0] ra;
      logic [7:0] rb;
      ra = 8'($urandom);
      rb = ($urandom % 3 == 0) ? ra : 8'($urandom);
      run_cmp(ra, rb, 1'($urandom));
    end

    summary();
    $finish;
  end

endmodule